// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

The sequencer walks a set of analog inputs on an external serial converter whose result always comes back one command late. A single trigger pulse captures a channel-enable mask. For every enabled logical channel, lowest index first, the block issues one start-conversion command frame. After each such frame it waits for the converter's end-of-conversion rising edge. Each command frame returns a 16-bit word, but that word belongs to the conversion the previous frame started. The block therefore drops the word from the first frame of a scan. It tags each later word with the channel converted one frame earlier, and it closes the scan with one read-status frame that brings back the last result.

Frames are exchanged through a request/acknowledge port. A serial shifter elsewhere on the chip moves the command byte out and the received word in. Results leave through a one-entry valid/ready register as sign-extended 13-bit samples, each carrying its logical channel number. Logical channels `0..NUM_IN-1` are single-ended inputs. Channel `NUM_IN+d` is the differential pair with input `d` as the positive leg and input `d^1` as the negative leg. `NUM_IN` is 8 or 2.

Top module: `adc_scan_ctrl`

## Requirements
- R1: In the eight-input variant, the command byte for single-ended channel i (0..7) has bit 7 set, the mux code {i[0], i[2:1]} in bits 6:4 and zeros in bits 3:0. This maps inputs 0..7 to codes 0,4,1,5,2,6,3,7.
- R2: In the eight-input variant, the command byte for logical channel 8+d (pair d, d^1) has bit 7 clear, the mux code of input d in bits 6:4 and zeros in bits 3:0.
- R3: In the two-input variant, the byte built as in R1/R2 (and the status byte) is sent with bits 7:6 kept, bits 3:0 moved to bits 5:2 and bits 1:0 zero. For example, channel 1 is 0xC0, channel 3 (pair 1-0) is 0x40 and status is 0x30.
- R4: A scan sends exactly one conversion frame per enabled channel, in ascending channel order.
- R5: The word received in a scan's first frame produces no sample. The word received in frame k+1 is emitted tagged with the channel of frame k.
- R6: After the last conversion, one read-status frame (byte 0x0C in the eight-input variant) is sent, and its word is emitted as the last channel's sample.
- R7: A sample is received-word bits 15:3 taken as a 13-bit two's-complement value, sign-extended to the output width.
- R8: No frame is requested after a conversion frame until a rising edge is seen on the end-of-conversion input.
- R9: If no such edge arrives within TIMEOUT_CYC cycles, the scan ends. No further frames are requested and no further samples are emitted.
- R10: A trigger with an all-zero mask requests no frame and emits no sample.
- R11: A trigger while a scan is in progress is ignored. Neither its mask nor the pulse changes the running scan.
- R12: A pending sample holds its data and channel until accepted, and no frame is requested while a sample is pending.
- R13: During and right after reset, no frame is requested and no sample is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_go | input | 1 | Trigger pulse, sampled only when idle |
| scan_mask | input | NCH | Channel-enable mask captured with the trigger |
| cmd_req | output | 1 | Frame request, held until acknowledged |
| cmd_byte | output | 8 | Command byte for the requested frame |
| cmd_ack | input | 1 | One-cycle pulse: frame finished |
| cmd_rdata | input | 16 | Word received in the finished frame, valid with cmd_ack |
| eoc | input | 1 | End-of-conversion from the converter, rising edge used |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sample accepted when high with smp_valid |
| smp_data | output | OUT_W | Sign-extended sample |
| smp_chan | output | CH_W | Logical channel of the sample |

## Verification
A realignment fault shows up at the very next acknowledged frame: a sample tagged with the wrong channel, or a word that belongs to the neighbouring conversion. The bench's converter model gives every conversion its own random word, so such a fault cannot hide. A corrupted pending mask or cursor shows up on the next command byte, or as a frame count that differs from the enabled-bit count plus one when the scan ends. A wait state that ignores the edge or the timer shows up either as a request while the model still holds end-of-conversion low, or as frames that keep coming after the model stopped answering.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_WAIT,
    S_STAT
  } scan_st_e;

  // converter instruction that returns data without starting a conversion
  localparam logic [7:0] STATUS_CMD = 8'h0C;

  // position of the sample inside a received word
  localparam int unsigned SMP_BITS = 13;
  localparam int unsigned SMP_LSB  = 3;

endpackage

// File: rtl/adc_scan_pick.sv
// Lowest set bit of the pending mask, as a binary index.
module adc_scan_pick #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IW    = 4
) (
  input  logic [WIDTH-1:0] pend,
  output logic [IW-1:0]    first_idx
);

  always_comb begin
    first_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend[i]) first_idx = IW'(i);
    end
  end

endmodule

// File: rtl/adc_scan_cmd.sv
// Command byte for a logical channel, or the status read.
module adc_scan_cmd
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned CH_W   = 4
) (
  input  logic [CH_W-1:0] ch,
  input  logic            stat_sel,
  output logic [7:0]      cmd
);

  logic [7:0] raw;

  generate
    if (NUM_IN == 2) begin : g_two
      // top bit of ch selects differential; ch[0] is the input / pair head
      always_comb begin
        raw = stat_sel ? STATUS_CMD : {~ch[1], ch[0], 6'b000000};
        // narrow part: low nibble shifts up by two, top two bits stay
        cmd = (raw & 8'hC0) | {raw[5:0] & 6'b001111, 2'b00};
      end
    end else begin : g_eight
      always_comb begin
        raw = stat_sel ? STATUS_CMD : {~ch[3], ch[0], ch[2:1], 4'b0000};
        cmd = raw;
      end
    end
  endgenerate

endmodule

// File: rtl/adc_scan_tmo.sv
// Counts cycles while run is high; flags the last allowed cycle.
module adc_scan_tmo #(
  parameter int unsigned LIMIT = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = run ? cnt_q + 1'b1 : '0;
    expired = run && (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter  int unsigned NUM_IN      = 8,
  parameter  int unsigned TIMEOUT_CYC = 20_000_000,
  parameter  int unsigned OUT_W       = 16,
  localparam int unsigned NCH         = 2 * NUM_IN,
  localparam int unsigned CH_W        = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_go,
  input  logic [NCH-1:0]   scan_mask,
  output logic             cmd_req,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_ack,
  input  logic [15:0]      cmd_rdata,
  input  logic             eoc,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [OUT_W-1:0] smp_data,
  output logic [CH_W-1:0]  smp_chan
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scan_st_e       st_q, st_d;
  logic [NCH-1:0] rem_q, rem_d;
  logic [CH_W-1:0] prev_q, prev_d;
  logic           first_q, first_d;
  logic           eoc_q;
  logic           eoc_rise;
  logic           tmo_hit;
  logic           load_smp;
  logic           smp_valid_d;
  logic [CH_W-1:0] pick_idx;

  adc_scan_pick #(.WIDTH(NCH), .IW(CH_W)) u_pick (
    .pend      (rem_q),
    .first_idx (pick_idx)
  );

  adc_scan_cmd #(.NUM_IN(NUM_IN), .CH_W(CH_W)) u_cmd (
    .ch       (pick_idx),
    .stat_sel (st_q == S_STAT),
    .cmd      (cmd_byte)
  );

  adc_scan_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (st_q == S_WAIT),
    .expired (tmo_hit)
  );

  assign eoc_rise = eoc && !eoc_q;
  // a frame starts only with the output register empty
  assign cmd_req  = ((st_q == S_SEND) || (st_q == S_STAT)) && !smp_valid;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    prev_d   = prev_q;
    first_d  = first_q;
    load_smp = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (scan_go && (|scan_mask)) begin
          rem_d   = scan_mask;
          first_d = 1'b1;
          st_d    = S_SEND;
        end
      end
      S_SEND: begin
        if (cmd_req && cmd_ack) begin
          rem_d    = rem_q & ~(NCH'(1) << pick_idx);
          prev_d   = pick_idx;
          first_d  = 1'b0;
          load_smp = !first_q;
          st_d     = S_WAIT;
        end
      end
      S_WAIT: begin
        if (tmo_hit)       st_d = S_IDLE;
        else if (eoc_rise) st_d = (|rem_q) ? S_SEND : S_STAT;
      end
      S_STAT: begin
        if (cmd_req && cmd_ack) begin
          load_smp = 1'b1;
          st_d     = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    if (load_smp)                    smp_valid_d = 1'b1;
    else if (smp_valid && smp_ready) smp_valid_d = 1'b0;
    else                             smp_valid_d = smp_valid;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q      <= S_IDLE;
      rem_q     <= '0;
      prev_q    <= '0;
      first_q   <= 1'b0;
      eoc_q     <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      rem_q     <= rem_d;
      prev_q    <= prev_d;
      first_q   <= first_d;
      eoc_q     <= eoc;
      smp_valid <= smp_valid_d;
    end
  end

  // sample payload: written only when a result is captured
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      smp_data <= '0;
      smp_chan <= '0;
    end else if (load_smp) begin
      smp_data <= OUT_W'($signed(cmd_rdata) >>> SMP_LSB);
      smp_chan <= prev_q;
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned CH_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_req,
  input logic             cmd_ack,
  input logic [7:0]       cmd_byte,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [OUT_W-1:0] smp_data,
  input logic [CH_W-1:0]  smp_chan
);

  localparam logic [7:0] STAT_B = (NUM_IN == 2) ? 8'h30 : 8'h0C;

  p_hold_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_chan)));

  p_no_frame_while_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !cmd_req);

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_byte)));

  p_wait_after_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_ack && (cmd_byte != STAT_B)) |=> !cmd_req);

  p_sign_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((&smp_data[OUT_W-1:12]) || !(|smp_data[OUT_W-1:12])));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r13: assert (!cmd_req && !smp_valid);
    end
  end

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .NUM_IN (NUM_IN),
  .OUT_W  (OUT_W),
  .CH_W   (CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_req   (cmd_req),
  .cmd_ack   (cmd_ack),
  .cmd_byte  (cmd_byte),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .smp_chan  (smp_chan)
);

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;

  localparam int TMO = 400;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  // eight-input instance
  logic        scan_go;
  logic [15:0] scan_mask;
  logic        cmd_req, cmd_ack;
  logic [7:0]  cmd_byte;
  logic [15:0] cmd_rdata;
  logic        eoc;
  logic        smp_valid, smp_ready;
  logic [15:0] smp_data;
  logic [3:0]  smp_chan;

  adc_scan_ctrl #(.NUM_IN(8), .TIMEOUT_CYC(TMO), .OUT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .scan_mask(scan_mask),
    .cmd_req(cmd_req), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
    .eoc(eoc), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_chan(smp_chan));

  // two-input instance
  logic        go2;
  logic [3:0]  mask2;
  logic        req2, ack2;
  logic [7:0]  byte2;
  logic [15:0] rdata2;
  logic        eoc2;
  logic        valid2, ready2;
  logic [15:0] data2;
  logic [1:0]  chan2;

  adc_scan_ctrl #(.NUM_IN(2), .TIMEOUT_CYC(TMO), .OUT_W(16)) uut2 (
    .clk(clk), .rst_n(rst_n), .scan_go(go2), .scan_mask(mask2),
    .cmd_req(req2), .cmd_byte(byte2), .cmd_ack(ack2), .cmd_rdata(rdata2),
    .eoc(eoc2), .smp_valid(valid2), .smp_ready(ready2),
    .smp_data(data2), .smp_chan(chan2));

  int n_chk = 0;
  int n_bad = 0;

  // scan expectations shared with the models
  int          exp_n;
  int          exp_ch [16];
  logic [15:0] conv_w [16];
  int          frm_cnt;
  int          smp_cnt;
  int          block_k;
  bit          blocked;

  function automatic logic [7:0] cmd8(input int c);
    int i;
    logic [2:0] m;
    i = (c < 8) ? c : c - 8;
    m = {i[0], i[2:1]};
    return {(c < 8) ? 1'b1 : 1'b0, m, 4'b0000};
  endfunction

  function automatic logic [15:0] sext(input logic [15:0] w);
    return {{3{w[15]}}, w[15:3]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
  endtask

  // converter and frame-engine model for the eight-input instance
  initial begin
    int eoc_cnt;
    int eoc_hi;
    cmd_ack = 1'b0; cmd_rdata = '0; eoc = 1'b0;
    eoc_cnt = 0; eoc_hi = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cmd_ack = 1'b0; eoc = 1'b0; eoc_cnt = 0; eoc_hi = 0;
      end else begin
        if (eoc_hi > 0) begin
          eoc_hi--;
          if (eoc_hi == 0) eoc = 1'b0;
        end
        if (cmd_ack) begin
          cmd_ack = 1'b0;
        end else if (eoc_cnt > 0) begin
          if (cmd_req) chk(1'b0, "R8 request before end of conversion", 1, 0);
          eoc_cnt--;
          if (eoc_cnt == 0) begin eoc = 1'b1; eoc_hi = 2; end
        end else if (blocked) begin
          if (cmd_req) chk(1'b0, "R9 request after abandoned conversion", 1, 0);
        end else if (cmd_req && ($urandom % 2 == 1)) begin
          int k;
          logic [7:0] eb;
          k = frm_cnt;
          if (k > exp_n) begin
            chk(1'b0, "R6 extra frame", k, exp_n);
          end else if (k < exp_n) begin
            eb = cmd8(exp_ch[k]);
            chk(cmd_byte == eb, (exp_ch[k] >= 8) ? "R2 diff command" : "R1 single command",
                cmd_byte, eb);
          end else begin
            chk(cmd_byte == 8'h0C, "R6 status command", cmd_byte, 8'h0C);
          end
          cmd_rdata = (k == 0) ? 16'($urandom) : conv_w[k-1];
          if (k < exp_n) begin
            conv_w[k] = 16'($urandom);
            if (k == block_k) blocked = 1'b1;
            else eoc_cnt = 1 + int'($urandom % 5);
          end
          cmd_ack = 1'b1;
          frm_cnt++;
        end
      end
    end
  end

  // sample consumer for the eight-input instance
  initial begin
    bit held;
    logic [15:0] hd;
    logic [3:0]  hc;
    held = 1'b0; hd = '0; hc = '0;
    smp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        smp_ready = 1'b0; held = 1'b0;
      end else begin
        bit rdy;
        rdy = ($urandom % 3) != 0;
        smp_ready = rdy;
        if (smp_valid && cmd_req) chk(1'b0, "R12 frame while sample pending", 1, 0);
        if (held && !smp_valid) chk(1'b0, "R12 pending sample dropped", 0, 1);
        if (smp_valid) begin
          if (held) begin
            chk(smp_data == hd, "R12 held data", smp_data, hd);
            chk(smp_chan == hc, "R12 held channel", smp_chan, hc);
          end
          if (rdy) begin
            int j;
            j = smp_cnt;
            if (j >= exp_n) begin
              chk(1'b0, "R5 unexpected sample", j, exp_n);
            end else begin
              chk(smp_chan == 4'(exp_ch[j]), "R5 sample channel", smp_chan, exp_ch[j]);
              chk(smp_data == sext(conv_w[j]), "R7 sample value", smp_data, sext(conv_w[j]));
            end
            smp_cnt++;
            held = 1'b0;
          end else begin
            held = 1'b1; hd = smp_data; hc = smp_chan;
          end
        end else begin
          held = 1'b0;
        end
      end
    end
  end

  task automatic run_scan(input logic [15:0] m, input int blk, input bit retrig);
    int n;
    n = 0;
    for (int c = 0; c < 16; c++) begin
      if (m[c]) begin exp_ch[n] = c; n++; end
    end
    frm_cnt = 0; smp_cnt = 0; block_k = blk; blocked = 1'b0; exp_n = n;
    @(negedge clk);
    scan_go = 1'b1; scan_mask = m;
    @(negedge clk);
    scan_go = 1'b0; scan_mask = 16'($urandom);
    if (retrig && n > 0) begin
      for (int w = 0; w < 500 && frm_cnt < 1; w++) @(negedge clk);
      scan_go = 1'b1; scan_mask = ~m | 16'h0001;
      @(negedge clk);
      scan_go = 1'b0;
    end
    if (n == 0) begin
      repeat (40) @(negedge clk);
      chk(frm_cnt == 0, "R10 frames after empty trigger", frm_cnt, 0);
      chk(smp_cnt == 0, "R10 samples after empty trigger", smp_cnt, 0);
    end else if (blk >= 0) begin
      repeat (TMO + 200) @(negedge clk);
      chk(frm_cnt == blk + 1, "R9 frames before timeout", frm_cnt, blk + 1);
      chk(smp_cnt == blk, "R9 samples before timeout", smp_cnt, blk);
      blocked = 1'b0;
    end else begin
      for (int w = 0; w < 4000 && smp_cnt < n; w++) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(frm_cnt == n + 1, retrig ? "R11 frame count with retrigger" : "R4 frame count",
          frm_cnt, n + 1);
      chk(smp_cnt == n, retrig ? "R11 sample count with retrigger" : "R5 sample count",
          smp_cnt, n);
    end
  endtask

  task automatic wait_req2();
    for (int w = 0; w < 200 && !req2; w++) @(negedge clk);
  endtask

  task automatic eoc2_pulse();
    repeat (3) @(negedge clk);
    eoc2 = 1'b1;
    @(negedge clk);
    eoc2 = 1'b0;
  endtask

  task automatic two_input_scan();
    @(negedge clk);
    go2 = 1'b1; mask2 = 4'b1010;
    @(negedge clk);
    go2 = 1'b0; mask2 = 4'b0101;
    wait_req2();
    chk(byte2 == 8'hC0, "R3 channel 1 command", byte2, 8'hC0);
    rdata2 = 16'h1234; ack2 = 1'b1;
    @(negedge clk);
    ack2 = 1'b0;
    chk(!valid2, "R5 first word discarded", valid2, 0);
    eoc2_pulse();
    wait_req2();
    chk(byte2 == 8'h40, "R3 pair 1-0 command", byte2, 8'h40);
    rdata2 = 16'hA5A8; ack2 = 1'b1;
    @(negedge clk);
    ack2 = 1'b0;
    chk(valid2 && chan2 == 2'd1, "R5 two-input first sample channel", chan2, 1);
    chk(data2 == sext(16'hA5A8), "R7 negative sample", data2, sext(16'hA5A8));
    eoc2_pulse();
    wait_req2();
    chk(byte2 == 8'h30, "R3 status command", byte2, 8'h30);
    rdata2 = 16'h7FF8; ack2 = 1'b1;
    @(negedge clk);
    ack2 = 1'b0;
    chk(valid2 && chan2 == 2'd3, "R6 last sample channel", chan2, 3);
    chk(data2 == 16'h0FFF, "R7 largest positive sample", data2, 16'h0FFF);
    repeat (10) @(negedge clk);
    chk(!req2 && !valid2, "R6 scan ends after status frame", req2, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    rst_n = 1'b0;
    scan_go = 1'b0; scan_mask = '0;
    go2 = 1'b0; mask2 = '0; ack2 = 1'b0; rdata2 = '0; eoc2 = 1'b0; ready2 = 1'b1;
    exp_n = 0; frm_cnt = 0; smp_cnt = 0; block_k = -1; blocked = 1'b0;
    repeat (5) @(negedge clk);
    chk(!cmd_req && !smp_valid, "R13 idle during reset", {cmd_req, smp_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!cmd_req && !smp_valid, "R13 idle after reset", {cmd_req, smp_valid}, 0);
    chk(!req2 && !valid2, "R13 idle after reset, two-input", {req2, valid2}, 0);

    // directed corner cases
    run_scan(16'h0001, -1, 1'b0);
    run_scan(16'h0000, -1, 1'b0);
    run_scan(16'hFFFF, -1, 1'b1);
    run_scan(16'h8000, -1, 1'b0);
    run_scan(16'h0300, -1, 1'b0);
    run_scan(16'h00F0, 2, 1'b0);
    run_scan(16'h0042, 0, 1'b0);
    run_scan(16'h5A5A, -1, 1'b0);

    // random masks
    for (int s = 0; s < 25; s++) begin
      logic [15:0] m;
      m = 16'($urandom);
      case (s % 5)
        1: m = 16'(1) << ($urandom % 16);
        2: m = m & 16'($urandom) & 16'($urandom);
        4: m = (s == 4) ? 16'h0000 : m;
        default: ;
      endcase
      run_scan(m, -1, (s % 3) == 0);
    end

    two_input_scan();

    summary();
    $finish;
  end

endmodule